// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Majority Voting

This block recovers 8-bit characters from an asynchronous serial line framed as one start bit, eight data bits sent least significant bit first, and one stop bit. A companion divider supplies a one-cycle enable at sixteen times the bit rate. All timing inside a character counts from the enable on which a falling edge of the synchronized line is first seen. Each bit is sampled three times around its centre, and the majority of those samples gives the bit value. If the three samples of any bit in the character differ, the character is marked as noisy.

The character and its flags are delivered when the stop bit's centre has been sampled. The block does not wait for the end of the stop bit. It is ready for the next start edge shortly after that point. A transmitter running slightly fast, or one that trims its stop bit, is therefore still received. A low pulse too short to be a real start bit is dropped without output.

Top module: `ovs_uart_rx`

## Requirements
- R1: While reset is asserted and after its release, rx_valid, frame_err and noise_err are 0 and rx_data is 8'h00.
- R2: A frame with eight data bits received LSB first (first data bit into rx_data[0]) produces rx_data equal to the sent byte and a rx_valid pulse exactly one clock cycle wide. rx_data and the flags change only in the cycle rx_valid is 1.
- R3: Counting the detecting enable as tick 0, each bit is sampled at ticks 7, 8 and 9 of its sixteen. The bit value is the majority of these samples, so a disturbance lasting one enable period near a bit centre does not corrupt the byte.
- R4: noise_err is 1 with a character when the three samples of any of its bits (start, data or stop) disagreed. It is 0 for a clean character.
- R5: frame_err is 1 with a character whose voted stop-bit value is 0, and 0 when that value is 1. The data byte is still delivered.
- R6: A low pulse whose voted start-bit centre is 1 is discarded: no rx_valid follows, and a later clean frame is received correctly.
- R7: rx_valid rises during the stop bit, more than nine and less than ten bit periods after the start edge.
- R8: Start detection is re-enabled at tick 10 of the stop bit. A character followed by a stop bit only 12/16 of a bit long and an immediate next start bit yields both bytes, in order.
- R9: Frames whose bit period is 3 % shorter or longer than sixteen enable periods decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: new byte and flags |
| frame_err | output | 1 | Voted stop bit was 0 for the current byte |
| noise_err | output | 1 | Sample disagreement within the current byte |

## Verification
The bench builds the block with its defaults: sixteen enables per bit, eight data bits and a two-stage synchronizer. It pulses the enable on every second clock. Because each enable period spans two clocks, the bench can place a disturbance exactly one enable wide on a chosen bit centre, which changes exactly one of the three votes. With this pacing the bench can also reach a 3 % rate offset by changing the bit period by a single clock, and can shorten a stop bit to a whole number of enable periods.

// File: rtl/ovs_uart_rx_pkg.sv
package ovs_uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // centre sample index inside a bit of osr ticks
  function automatic int unsigned mid_tick(input int unsigned osr);
    return osr / 2;
  endfunction

endpackage

// File: rtl/ovs_rx_sync.sv
module ovs_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = din;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/ovs_rx_vote.sv
module ovs_rx_vote #(
  parameter int unsigned OSR = 16,
  localparam int unsigned CW = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          active,
  input  logic [CW-1:0] tick_cnt,
  input  logic          rx_s,
  output logic          vote,
  output logic          split
);
  import ovs_uart_rx_pkg::*;

  localparam logic [CW-1:0] SMP_A = CW'(mid_tick(OSR) - 1);
  localparam logic [CW-1:0] SMP_B = CW'(mid_tick(OSR));

  logic samp_a_q, samp_b_q;
  logic samp_a_d, samp_b_d;

  always_comb begin
    samp_a_d = samp_a_q;
    samp_b_d = samp_b_q;
    if (active && os_tick) begin
      if (tick_cnt == SMP_A) samp_a_d = rx_s;
      if (tick_cnt == SMP_B) samp_b_d = rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_a_q <= 1'b1;
      samp_b_q <= 1'b1;
    end else begin
      samp_a_q <= samp_a_d;
      samp_b_q <= samp_b_d;
    end
  end

  // third sample is the live input on the decision tick
  assign vote  = (samp_a_q & samp_b_q) | (samp_a_q & rx_s) | (samp_b_q & rx_s);
  assign split = !((samp_a_q == samp_b_q) && (samp_b_q == rx_s));

endmodule

// File: rtl/ovs_rx_frame.sv
module ovs_rx_frame #(
  parameter int unsigned OSR       = 16,
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned CW = $clog2(OSR),
  localparam int unsigned BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick,
  input  logic                 rx_s,
  input  logic                 vote,
  input  logic                 split,
  output logic                 active,
  output logic [CW-1:0]        tick_cnt,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 ferr_o,
  output logic                 nerr_o
);
  import ovs_uart_rx_pkg::*;

  localparam logic [CW-1:0] SMP_HI   = CW'(mid_tick(OSR) + 1);
  localparam logic [CW-1:0] LAST_TCK = CW'(OSR - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

  rx_state_e            state_q, state_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [BW-1:0]        bit_q, bit_d;
  logic [DATA_BITS-1:0] shift_q, shift_d;
  logic                 noise_q, noise_d;
  logic                 prev_q, prev_d;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 valid_q, valid_d;
  logic                 fe_q, fe_d;
  logic                 ne_q, ne_d;
  logic                 decide;

  assign decide = os_tick && (cnt_q == SMP_HI);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    noise_d = noise_q;
    prev_d  = os_tick ? rx_s : prev_q;
    data_d  = data_q;
    valid_d = 1'b0;
    fe_d    = fe_q;
    ne_d    = ne_q;
    unique case (state_q)
      RX_IDLE: begin
        if (os_tick && prev_q && !rx_s) begin
          state_d = RX_START;
          cnt_d   = CW'(1);
          bit_d   = '0;
          noise_d = 1'b0;
        end
      end
      RX_START: begin
        if (os_tick) begin
          cnt_d = cnt_q + CW'(1);
          if (decide) begin
            noise_d = noise_q | split;
            if (vote) state_d = RX_IDLE;
          end
          if (cnt_q == LAST_TCK) begin
            cnt_d   = '0;
            state_d = RX_DATA;
          end
        end
      end
      RX_DATA: begin
        if (os_tick) begin
          cnt_d = cnt_q + CW'(1);
          if (decide) begin
            noise_d = noise_q | split;
            if (DATA_BITS > 1) shift_d = {vote, shift_q[DATA_BITS-1:1]};
            else               shift_d = vote;
          end
          if (cnt_q == LAST_TCK) begin
            cnt_d = '0;
            if (bit_q == LAST_BIT) state_d = RX_STOP;
            else                   bit_d   = bit_q + BW'(1);
          end
        end
      end
      RX_STOP: begin
        if (os_tick) begin
          cnt_d = cnt_q + CW'(1);
          if (decide) begin
            valid_d = 1'b1;
            data_d  = shift_q;
            fe_d    = !vote;
            ne_d    = noise_q | split;
            state_d = RX_IDLE;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      noise_q <= 1'b0;
      prev_q  <= 1'b1;
      data_q  <= '0;
      valid_q <= 1'b0;
      fe_q    <= 1'b0;
      ne_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      noise_q <= noise_d;
      prev_q  <= prev_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      fe_q    <= fe_d;
      ne_q    <= ne_d;
    end
  end

  assign active   = (state_q != RX_IDLE);
  assign tick_cnt = cnt_q;
  assign data_o   = data_q;
  assign valid_o  = valid_q;
  assign ferr_o   = fe_q;
  assign nerr_o   = ne_q;

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(data_q));

  // R5
  ferr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(fe_q));

  // R4
  noise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(ne_q));

  // R7
  deliver_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($past(state_q) == RX_STOP));

endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx #(
  parameter int unsigned OSR         = 16,
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick,
  input  logic                 rx_serial,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 frame_err,
  output logic                 noise_err
);

  localparam int unsigned CW = $clog2(OSR);

  logic          rx_s;
  logic          vote, split, active;
  logic [CW-1:0] tick_cnt;

  ovs_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_serial),
    .dout (rx_s)
  );

  ovs_rx_vote #(.OSR(OSR)) u_vote (
    .clk     (clk),
    .rst_n   (rst_n),
    .os_tick (os_tick),
    .active  (active),
    .tick_cnt(tick_cnt),
    .rx_s    (rx_s),
    .vote    (vote),
    .split   (split)
  );

  ovs_rx_frame #(.OSR(OSR), .DATA_BITS(DATA_BITS)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .os_tick (os_tick),
    .rx_s    (rx_s),
    .vote    (vote),
    .split   (split),
    .active  (active),
    .tick_cnt(tick_cnt),
    .data_o  (rx_data),
    .valid_o (rx_valid),
    .ferr_o  (frame_err),
    .nerr_o  (noise_err)
  );

endmodule

// File: tb/test_ovs_uart_rx.sv
module test_ovs_uart_rx;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CLK    = 16 * TICK_DIV;
  localparam int NVEC       = 8;

  // [31:24] byte, [23:16] bit period in clocks, [15:8] stop length in clocks,
  // [7:4] glitched bit (0 start, 1..8 data, 9 stop, 15 none),
  // [2] stop driven low, [1] expected frame_err, [0] expected noise_err
  localparam logic [31:0] VEC [NVEC] = '{
    {8'hA5, 8'd32, 8'd32, 4'hF, 4'b0000},  // R2
    {8'h01, 8'd32, 8'd32, 4'hF, 4'b0000},  // R2
    {8'h80, 8'd31, 8'd31, 4'hF, 4'b0000},  // R9 fast
    {8'h7E, 8'd33, 8'd33, 4'hF, 4'b0000},  // R9 slow
    {8'h3C, 8'd32, 8'd32, 4'h3, 4'b0001},  // R3 R4 data glitch
    {8'hC3, 8'd32, 8'd32, 4'h0, 4'b0001},  // R4 start glitch
    {8'h55, 8'd32, 8'd32, 4'hF, 4'b0110},  // R5 stop low
    {8'hFF, 8'd32, 8'd32, 4'hF, 4'b0000}   // R4 R5 clean
  };

  logic       clk, rst_n, os_tick, rx_serial;
  logic [7:0] rx_data;
  logic       rx_valid, frame_err, noise_err;

  int checks = 0, errors = 0;
  int cyc = 0, got_cnt = 0, width_bad = 0, got_cyc = 0;
  logic [7:0] got_data = 0, got_prev = 0;
  logic got_fe = 0, got_ne = 0, last_v = 0;
  int tick_div_cnt = 0;
  bit done = 0;

  ovs_uart_rx i_ovs_uart_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_serial(rx_serial),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .frame_err(frame_err), .noise_err(noise_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tick_div_cnt <= (tick_div_cnt == TICK_DIV-1) ? 0 : tick_div_cnt + 1;
  end
  assign os_tick = (tick_div_cnt == 0);

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rx_valid) begin
      if (last_v) width_bad = width_bad + 1;
      got_prev = got_data;
      got_data = rx_data;
      got_fe   = frame_err;
      got_ne   = noise_err;
      got_cnt  = got_cnt + 1;
      got_cyc  = cyc;
    end
    last_v = rx_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input int len, input bit glitch);
    rx_serial = v;
    if (glitch) begin
      repeat (len/2) @(negedge clk);
      rx_serial = ~v;
      repeat (TICK_DIV) @(negedge clk);
      rx_serial = v;
      repeat (len - len/2 - TICK_DIV) @(negedge clk);
    end else begin
      repeat (len) @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] d, input int bitclk, input int stopclk,
                      input int gbit, input bit stop_low, output int start_cyc);
    @(negedge clk);
    start_cyc = cyc;
    drive_bit(1'b0, bitclk, gbit == 0);
    for (int b = 0; b < 8; b++) drive_bit(d[b], bitclk, gbit == b + 1);
    drive_bit(!stop_low, stopclk, gbit == 9);
    rx_serial = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int sc, n0;
    rx_serial = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R1 during reset
    chk(rx_valid == 0, "R1", rx_valid, 0);
    chk(rx_data == 8'h00, "R1", rx_data, 0);
    rst_n = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    // R1 after release
    chk(rx_valid == 0 && got_cnt == 0, "R1", got_cnt, 0);
    chk(frame_err == 0 && noise_err == 0, "R1", {frame_err, noise_err}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      v  = VEC[i];
      n0 = got_cnt;
      send(v[31:24], int'(v[23:16]), int'(v[15:8]), int'(v[7:4]), v[2], sc);
      if (i == 0) begin
        // R7 delivery inside the stop bit
        chk((got_cyc - sc) > 9 * BIT_CLK && (got_cyc - sc) < 10 * BIT_CLK,
            "R7", got_cyc - sc, 9 * BIT_CLK + BIT_CLK/2);
      end
      repeat (3 * BIT_CLK) @(negedge clk);
      chk(got_cnt == n0 + 1, "R2 count", got_cnt - n0, 1);
      chk(got_data == v[31:24], "R2 R3 R9 data", got_data, v[31:24]);
      chk(got_fe == v[1], "R5 frame_err", got_fe, v[1]);
      chk(got_ne == v[0], "R4 noise_err", got_ne, v[0]);
    end

    // R6 short low pulse rejected
    n0 = got_cnt;
    @(negedge clk);
    rx_serial = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rx_serial = 1'b1;
    repeat (12 * BIT_CLK) @(negedge clk);
    chk(got_cnt == n0, "R6 no output", got_cnt - n0, 0);
    send(8'h96, BIT_CLK, BIT_CLK, 15, 1'b0, sc);
    repeat (3 * BIT_CLK) @(negedge clk);
    chk(got_cnt == n0 + 1 && got_data == 8'h96, "R6 recovery", got_data, 8'h96);

    // R8 short stop bit, next start immediately
    n0 = got_cnt;
    send(8'h12, BIT_CLK, 12 * TICK_DIV, 15, 1'b0, sc);
    send(8'h34, BIT_CLK, BIT_CLK, 15, 1'b0, sc);
    repeat (3 * BIT_CLK) @(negedge clk);
    chk(got_cnt == n0 + 2, "R8 count", got_cnt - n0, 2);
    chk(got_prev == 8'h12, "R8 first", got_prev, 8'h12);
    chk(got_data == 8'h34 && got_fe == 0, "R8 second", got_data, 8'h34);

    // R2 every strobe one cycle wide
    chk(width_bad == 0, "R2 width", width_bad, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule